// File: doc/BRIEF.md
# Interrupt / Frequency-Test Pin Selector

This block decides what drives a single active-low, open-drain pin that is shared between an alarm interrupt and a clock frequency test. When the test mode is selected, the pin carries a 512 Hz square wave made by dividing a 32.768 kHz tick enable by 64. When it is not, the pin is pulled low while an enabled alarm request is pending and released otherwise.

Test mode needs four things at once: the oscillator is running, the frequency-test control bit is set, the alarm-enable bit is clear, and either the watchdog steering bit is set or the whole watchdog register reads zero. Every control input is captured in a register that reset clears, so coming out of reset the frequency-test control reads 0 and the pin is released. The pin is modelled as a drive-low enable and the level a pull-up would give.

Top module: `irqft_pin_selector`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `pin_drive_low` is 0 and `pin_level` is 1. All captured controls, the frequency-test control among them, read 0 after reset.
- R2: With `osc_run`=1, `ft_bit`=1, `alarm_en`=0 and `wd_steer`=1, the pin alternates between released and driven low, and each state lasts exactly 32 `tick_32k` pulses (one full period is 64 ticks, which is 512 Hz at a 32.768 kHz tick).
- R3: With `wd_steer`=0, test mode is still selected when `wd_reg` equals 8'h00 and the other R2 conditions hold.
- R4: With `wd_steer`=0 and `wd_reg` nonzero, test mode is not selected and the pin follows `alarm_irq`.
- R5: `alarm_en`=1 deselects test mode, whatever the other controls are.
- R6: `osc_run`=0 deselects test mode. With the test function chosen but no oscillator, no square wave appears.
- R7: Outside test mode, `pin_drive_low` equals the value `alarm_irq` had two clocks earlier.
- R8: Deselecting test mode restarts the divider. After test mode is selected again, with a tick on every clock, the pin stays released for 33 clocks after the control change and is driven low on the 34th.
- R9: `pin_level` is always the inverse of `pin_drive_low`. The pin only pulls low and otherwise floats to the pulled-up high.
- R10: While test mode is not selected, tick pulses have no effect. Inside test mode, clocks without a tick do not advance the square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_run | input | 1 | 1 while the timekeeping oscillator runs |
| ft_bit | input | 1 | Frequency-test control bit |
| alarm_en | input | 1 | Alarm-enable control bit |
| wd_steer | input | 1 | Watchdog steering bit |
| wd_reg | input | 8 | Whole watchdog register value |
| alarm_irq | input | 1 | Pending, enabled alarm interrupt request |
| tick_32k | input | 1 | One-clock enable at 32.768 kHz |
| pin_drive_low | output | 1 | 1 = pull the pin low |
| pin_level | output | 1 | Resulting pin level with a pull-up |

## Verification
A control or alarm change applied before clock edge k is captured at k and reaches `pin_drive_low` at edge k+1, so it is seen two clocks later. A tick that completes a half-period toggles the wave at its own edge and reaches the pin one edge later. The bench changes inputs only on falling edges and keeps a cycle model with the same two-stage timing, then compares the pin after each falling edge. The R8 restart case counts falling edges directly: the pin must be released after 33 of them and driven low after 34.

// File: rtl/irqft_pkg.sv
package irqft_pkg;

  // Captured control state feeding the mode decision and the pin stage.
  typedef struct packed {
    logic osc;      // oscillator running
    logic ft;       // frequency-test control
    logic ae;       // alarm enable
    logic wds;      // watchdog steering
    logic wd_zero;  // watchdog register reads all zeros
    logic irq;      // alarm request
  } irqft_ctrl_t;

  localparam irqft_ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/irqft_ctrl_capture.sv
module irqft_ctrl_capture
  import irqft_pkg::*;
#(
  parameter int WD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_run,
  input  logic              ft_bit,
  input  logic              alarm_en,
  input  logic              wd_steer,
  input  logic [WD_W-1:0]   wd_reg,
  input  logic              alarm_irq,
  output irqft_ctrl_t       ctrl_q
);

  // Zero detect over the watchdog register as an OR chain.
  logic [WD_W:0] any_set;
  assign any_set[0] = 1'b0;

  for (genvar b = 0; b < WD_W; b++) begin : g_wd_or
    assign any_set[b+1] = any_set[b] | wd_reg[b];
  end

  irqft_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d.osc     = osc_run;
    ctrl_d.ft      = ft_bit;
    ctrl_d.ae      = alarm_en;
    ctrl_d.wds     = wd_steer;
    ctrl_d.wd_zero = ~any_set[WD_W];
    ctrl_d.irq     = alarm_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/irqft_mode_decode.sv
module irqft_mode_decode
  import irqft_pkg::*;
(
  input  irqft_ctrl_t ctrl,
  output logic        test_sel
);

  logic wd_allows;

  always_comb begin
    wd_allows = ctrl.wds | ctrl.wd_zero;
    test_sel  = ctrl.osc & ctrl.ft & ~ctrl.ae & wd_allows;
  end

endmodule

// File: rtl/irqft_divider.sv
module irqft_divider #(
  parameter int HALF_TICKS = 32,
  localparam int CNT_W     = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic             wave,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             wave_d;
  logic             adv;

  always_comb begin
    adv    = run & tick;
    cnt_d  = cnt;
    wave_d = wave;
    if (!run) begin
      cnt_d  = '0;
      wave_d = 1'b0;
    end else if (adv) begin
      if (cnt == LAST) begin
        cnt_d  = '0;
        wave_d = ~wave;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      wave <= wave_d;
    end
  end

endmodule

// File: rtl/irqft_pin_selector.sv
module irqft_pin_selector
  import irqft_pkg::*;
#(
  parameter int WD_W       = 8,
  parameter int HALF_TICKS = 32,
  localparam int CNT_W     = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_run,
  input  logic            ft_bit,
  input  logic            alarm_en,
  input  logic            wd_steer,
  input  logic [WD_W-1:0] wd_reg,
  input  logic            alarm_irq,
  input  logic            tick_32k,
  output logic            pin_drive_low,
  output logic            pin_level
);

  irqft_ctrl_t      ctrl_q;
  logic             test_sel;
  logic             wave_w;
  logic [CNT_W-1:0] cnt_w;
  logic             drive_d;
  logic             drive_q;

  irqft_ctrl_capture #(.WD_W(WD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_run   (osc_run),
    .ft_bit    (ft_bit),
    .alarm_en  (alarm_en),
    .wd_steer  (wd_steer),
    .wd_reg    (wd_reg),
    .alarm_irq (alarm_irq),
    .ctrl_q    (ctrl_q)
  );

  irqft_mode_decode u_dec (
    .ctrl     (ctrl_q),
    .test_sel (test_sel)
  );

  irqft_divider #(.HALF_TICKS(HALF_TICKS)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (test_sel),
    .tick  (tick_32k),
    .wave  (wave_w),
    .cnt   (cnt_w)
  );

  // Pin stage: square wave in test mode, alarm request otherwise.
  always_comb begin
    drive_d = test_sel ? wave_w : ctrl_q.irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_d;
  end

  assign pin_drive_low = drive_q;
  assign pin_level     = ~drive_q;

endmodule

// File: rtl/irqft_pin_selector_chk.sv
module irqft_pin_selector_chk #(
  parameter int CNT_W = 5,
  parameter int HALF_TICKS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_run,
  input logic             alarm_en,
  input logic             tick_32k,
  input logic             test_sel,
  input logic             irq_q,
  input logic             wave_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             pin_drive_low,
  input logic             pin_level
);

  // R1: first clock after reset release leaves the pin released
  a_r1_reset_released: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !pin_drive_low);

  // R5: an alarm enable seen at the previous edge forbids test mode
  a_r5_ae_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(alarm_en) |-> !test_sel);

  // R6: stopped oscillator forbids test mode
  a_r6_osc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osc_run) |-> !test_sel);

  // R7: outside test mode the pin follows the captured request
  a_r7_follow_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !test_sel |=> pin_drive_low == $past(irq_q));

  // R8: deselection clears the divider
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !test_sel |=> (!wave_w && cnt_w == '0));

  // R10: no tick, no change of the wave
  a_r10_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel && !tick_32k) |=> $stable(wave_w));

  // R2: the wave only toggles on a tick that ends a half-period
  a_r2_toggle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel && !(tick_32k && cnt_w == CNT_W'(HALF_TICKS - 1))) |=> $stable(wave_w));

  // R9: the pin level is the inverse of the pull-down enable
  a_r9_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    pin_level != pin_drive_low);

endmodule

bind irqft_pin_selector irqft_pin_selector_chk #(.CNT_W(CNT_W), .HALF_TICKS(HALF_TICKS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .osc_run       (osc_run),
  .alarm_en      (alarm_en),
  .tick_32k      (tick_32k),
  .test_sel      (test_sel),
  .irq_q         (ctrl_q.irq),
  .wave_w        (wave_w),
  .cnt_w         (cnt_w),
  .pin_drive_low (pin_drive_low),
  .pin_level     (pin_level)
);

// File: tb/irqft_pin_selector_test.sv
module irqft_pin_selector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_run = 1'b0, ft_bit = 1'b0, alarm_en = 1'b0, wd_steer = 1'b0;
  logic [7:0] wd_reg = 8'h00;
  logic       alarm_irq = 1'b0, tick_32k = 1'b0;
  logic       pin_drive_low, pin_level;

  int n_checks = 0;
  int n_fail   = 0;
  string ctx   = "R1";
  bit done     = 0;

  always #10 clk = ~clk; // 50 MHz

  irqft_pin_selector uut (
    .clk(clk), .rst_n(rst_n), .osc_run(osc_run), .ft_bit(ft_bit),
    .alarm_en(alarm_en), .wd_steer(wd_steer), .wd_reg(wd_reg),
    .alarm_irq(alarm_irq), .tick_32k(tick_32k),
    .pin_drive_low(pin_drive_low), .pin_level(pin_level)
  );

  // Test mode rule from the requirements (R2, R3, R4, R5, R6).
  function automatic bit exp_test(bit osc, bit ft, bit ae, bit wds, logic [7:0] wd);
    return osc && ft && !ae && (wds || wd == 8'h00);
  endfunction

  // Cycle model: controls take effect one edge after sampling, pin one more.
  bit m_sel, m_irq, m_wave, m_drv;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_irq = 0; m_wave = 0; m_drv = 0; m_cnt = 0;
    end else begin
      m_drv = m_sel ? m_wave : m_irq;
      if (!m_sel) begin
        m_cnt = 0; m_wave = 0;
      end else if (tick_32k) begin
        if (m_cnt == 31) begin m_cnt = 0; m_wave = !m_wave; end
        else m_cnt = m_cnt + 1;
      end
      m_sel = exp_test(osc_run, ft_bit, alarm_en, wd_steer, wd_reg);
      m_irq = alarm_irq;
    end
  end

  task automatic check(string req, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Compare the pin with the model after the edge, then the level (R9).
  task automatic step(bit tk);
    @(negedge clk);
    check(ctx, pin_drive_low, m_drv);
    check("R9", pin_level, !m_drv);
    tick_32k = tk;
  endtask

  task automatic set_ctrl(bit osc, bit ft, bit ae, bit wds, logic [7:0] wd, bit irq);
    osc_run = osc; ft_bit = ft; alarm_en = ae; wd_steer = wds; wd_reg = wd; alarm_irq = irq;
  endtask

  task automatic run(int n, int tick_pct);
    for (int i = 0; i < n; i++) step(($urandom % 100) < tick_pct);
  endtask

  initial begin
    void'($urandom(32'd1554));
    // R1: reset state
    #25;
    check("R1", pin_drive_low, 1'b0);
    check("R1", pin_level, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", pin_drive_low, 1'b0);

    // R2: steering bit set, full periods with ticks every other clock
    ctx = "R2"; set_ctrl(1, 1, 0, 1, 8'h5A, 1); run(400, 50);
    // R3: steering clear, zero watchdog register
    ctx = "R3"; set_ctrl(1, 1, 0, 0, 8'h00, 1); run(300, 70);
    // R4: steering clear, nonzero register, request toggling
    ctx = "R4"; set_ctrl(1, 1, 0, 0, 8'h80, 1); run(5, 100);
    alarm_irq = 0; run(5, 100); alarm_irq = 1; run(5, 100);
    // R5: alarm enable blocks the test mode
    ctx = "R5"; set_ctrl(1, 1, 1, 1, 8'h00, 0); run(80, 100);
    // R6: oscillator stopped
    ctx = "R6"; set_ctrl(0, 1, 0, 1, 8'h00, 0); run(80, 100);
    // R7: request passes with two clocks of latency
    ctx = "R7"; set_ctrl(1, 0, 0, 0, 8'h11, 0); run(3, 0);
    alarm_irq = 1; @(negedge clk); check("R7", pin_drive_low, 1'b0);
    @(negedge clk); check("R7", pin_drive_low, 1'b1);
    alarm_irq = 0; run(4, 0);
    // R10: ticks outside test mode do nothing
    ctx = "R10"; run(100, 100);

    // R8: deselect mid-period, reselect, first half-period full length
    ctx = "R8"; set_ctrl(1, 1, 0, 1, 8'h00, 0); run(20, 100);
    ft_bit = 0; run(4, 100);
    ft_bit = 1; tick_32k = 1;
    for (int k = 1; k <= 34; k++) begin
      @(negedge clk);
      if (k == 33) check("R8", pin_drive_low, 1'b0);
      if (k == 34) check("R8", pin_drive_low, 1'b1);
    end
    run(100, 100);

    // Random mix, checked against the model
    for (int seg = 0; seg < 60; seg++) begin
      set_ctrl($urandom % 4 != 0, $urandom % 3 != 0, $urandom % 4 == 0,
               $urandom % 2, ($urandom % 2) ? 8'h00 : 8'($urandom), $urandom % 2);
      ctx = exp_test(osc_run, ft_bit, alarm_en, wd_steer, wd_reg) ? "R2" : "R4";
      run(200 + $urandom % 200, $urandom % 100);
    end
    done = 1;
  end

  initial begin
    wait (done || $time > 64'd3_000_000_000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule